// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading translation entries from memory. It serves one request at a time: the requester presents the address plus two attributes (write or read, user or supervisor), the walker reads a top-level entry, and then, unless that entry maps a large page, a second-level entry. It then checks the presence and permission bits and either answers with a physical address or with a fault and its cause. A separate write port loads the frame number of the top-level table. That frame number is the only state a context switch has to replace.

Every entry is one 32-bit word. The frame number sits in bits 31:12 and the flags sit in the low byte. When a walk succeeds and the final entry has not yet been marked as used, or has not been marked as modified by a write, the walker writes the entry back with those marks set before it answers. The answer also carries the final entry's write-through and cache-disable flags, so a cache further along the path can act on them.

The memory side is a plain request port. The walker holds its request, address, write enable and write data steady until the memory returns a single-cycle done pulse. On a read, that pulse carries the data.

Top module: `page_walker`

## Requirements
- R1: After reset, `busy`, `rspValid` and `memReq` are all low.
- R2: The first read of every walk uses the address {top-table frame, vaddr[31:22], 2'b00}. The top-table frame is the value last loaded through `rootWrEn`/`rootWrData`.
- R3: When the top-level entry is present (bit 0) and bit 7 is clear, the second read uses {entry[31:12], vaddr[21:12], 2'b00}. A successful result is {second entry[31:12], vaddr[11:0]}.
- R4: An entry with bit 0 clear, at either level, ends the walk with `rspCause` = 1. No further memory access is made. The physical address and both cache flags in the response are 0.
- R5: A present top-level entry with bit 7 set maps a 4 MB page. The walk makes no second read, and the physical address is {entry[31:22], vaddr[21:0]}.
- R6: The permission check uses the final entry. A write when bit 1 is clear, or a user access when bit 2 is clear, ends the walk with `rspCause` = 2, with no write-back, and with a zero address and zero flags.
- R7: On a permitted walk, if the final entry has bit 5 clear, or the access is a write and bit 6 is clear, the walker writes that entry back to the address it was read from before responding. The written value has bit 5 set, and also bit 6 set for a write. Otherwise the walk makes no write.
- R8: A successful response has `rspCause` = 0 and reports bit 3 of the final entry on `rspWriteThrough` and bit 4 on `rspCacheDisable`.
- R9: `busy` is high from the accepted request until the response appears, and never while `rspValid` is high. A request that arrives during a walk or while a response is pending is ignored. The response and its fields stay unchanged until `rspAck`.
- R10: `memReq`, `memWe`, `memAddr` and `memWdata` stay unchanged until `memDone`, whatever the memory latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rootWrEn | input | 1 | Load the top-table frame number |
| rootWrData | input | 20 | Frame number of the top-level table |
| reqValid | input | 1 | Translation request, sampled when idle |
| reqVaddr | input | 32 | Virtual address to translate |
| reqWrite | input | 1 | 1 = write access, 0 = read |
| reqUser | input | 1 | 1 = user access, 0 = supervisor |
| busy | output | 1 | Walk in progress |
| memReq | output | 1 | Memory access request, held until done |
| memWe | output | 1 | 1 = write access to memory |
| memAddr | output | 32 | Byte address of the entry |
| memWdata | output | 32 | Entry value to be written back |
| memDone | input | 1 | One-cycle completion of the memory access |
| memRdata | input | 32 | Read data, valid with `memDone` |
| rspValid | output | 1 | Response pending |
| rspCause | output | 2 | 0 = success, 1 = not present, 2 = permission denied |
| rspPaddr | output | 32 | Translated physical address (0 on a fault) |
| rspWriteThrough | output | 1 | Write-through flag of the final entry |
| rspCacheDisable | output | 1 | Cache-disable flag of the final entry |
| rspAck | input | 1 | Consumes the response |

## Verification
A wrong level marker or a stale table base shows up at once as a wrong `memAddr` on the second read, before any response exists, so the bench compares the full sequence of memory accesses and not only the final answer. A mis-latched entry or a wrong flag decision appears at the response one or two cycles after the last `memDone`: as the wrong cause, as a missing or extra write-back, or as an address built from the wrong offset width. A stuck control state shows as `busy` and `rspValid` high together, or as a second walk starting without a fresh request. Both are checked on every clock.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  localparam int FLAG_PRESENT   = 0;
  localparam int FLAG_WRITABLE  = 1;
  localparam int FLAG_USER      = 2;
  localparam int FLAG_WRTHROUGH = 3;
  localparam int FLAG_NOCACHE   = 4;
  localparam int FLAG_ACCESSED  = 5;
  localparam int FLAG_DIRTY     = 6;
  localparam int FLAG_LARGE     = 7;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_DIR, ST_CHK_DIR, ST_RD_PTE, ST_CHK_PTE, ST_WRBACK, ST_RESP
  } walkState_e;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0, CAUSE_ABSENT = 2'd1, CAUSE_DENIED = 2'd2
  } walkCause_e;

  typedef struct packed {
    logic loadReq;
    logic loadEntry;
    logic descend;
  } walkStrobe_t;
endpackage

// File: rtl/pgw_datapath.sv
module pgw_datapath
  import pgw_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int IDX_W = 10,
  parameter int OFF_W = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  walkStrobe_t        strobe,
  input  logic               rootWrEn,
  input  logic [VA_W-OFF_W-1:0] rootWrData,
  input  logic [VA_W-1:0]    reqVaddr,
  input  logic               reqWrite,
  input  logic               reqUser,
  input  logic [VA_W-1:0]    memRdata,
  output logic [VA_W-1:0]    memAddr,
  output logic [VA_W-1:0]    memWdata,
  output logic               entPresent,
  output logic               entLarge,
  output logic               permOk,
  output logic               needUpdate,
  output logic [VA_W-1:0]    pagePaddr,
  output logic               entWriteThrough,
  output logic               entCacheDisable
);
  localparam int FRAME_W  = VA_W - OFF_W;
  localparam int BIG_OFF  = OFF_W + IDX_W;
  localparam int ENT_SH   = OFF_W - IDX_W;

  logic [FRAME_W-1:0] rootBase;
  logic [FRAME_W-1:0] tableBase;
  logic [VA_W-1:0]    vaReg;
  logic [VA_W-1:0]    entry;
  logic               wrReg;
  logic               usrReg;
  logic               level2;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rootBase  <= '0;
      tableBase <= '0;
      vaReg     <= '0;
      entry     <= '0;
      wrReg     <= 1'b0;
      usrReg    <= 1'b0;
      level2    <= 1'b0;
    end else begin
      if (rootWrEn) rootBase <= rootWrData;
      if (strobe.loadReq) begin
        vaReg  <= reqVaddr;
        wrReg  <= reqWrite;
        usrReg <= reqUser;
        level2 <= 1'b0;
      end
      if (strobe.loadEntry) entry <= memRdata;
      if (strobe.descend) begin
        tableBase <= entry[VA_W-1:OFF_W];
        level2    <= 1'b1;
      end
    end
  end

  logic [VA_W-1:0] dirAddr;
  logic [VA_W-1:0] pteAddr;
  assign dirAddr = {rootBase,  vaReg[VA_W-1 -: IDX_W], ENT_SH'(0)};
  assign pteAddr = {tableBase, vaReg[OFF_W +: IDX_W],  ENT_SH'(0)};
  assign memAddr = level2 ? pteAddr : dirAddr;

  always_comb begin
    memWdata = entry;
    memWdata[FLAG_ACCESSED] = 1'b1;
    if (wrReg) memWdata[FLAG_DIRTY] = 1'b1;
  end

  assign entPresent      = entry[FLAG_PRESENT];
  assign entLarge        = entry[FLAG_LARGE];
  assign permOk          = !(wrReg && !entry[FLAG_WRITABLE]) && !(usrReg && !entry[FLAG_USER]);
  assign needUpdate      = !entry[FLAG_ACCESSED] || (wrReg && !entry[FLAG_DIRTY]);
  assign entWriteThrough = entry[FLAG_WRTHROUGH];
  assign entCacheDisable = entry[FLAG_NOCACHE];
  assign pagePaddr = level2 ? {entry[VA_W-1:OFF_W], vaReg[OFF_W-1:0]}
                            : {entry[VA_W-1:BIG_OFF], vaReg[BIG_OFF-1:0]};

  // R7: a write-back always carries the accessed mark, and the dirty mark for writes
  assert_wb_marks_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadReq) |=> (memWdata[FLAG_ACCESSED] && (memWdata[FLAG_DIRTY] || !wrReg)));
endmodule

// File: rtl/pgw_ctrl.sv
module pgw_ctrl
  import pgw_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        memDone,
  input  logic        rspAck,
  input  logic        entPresent,
  input  logic        entLarge,
  input  logic        permOk,
  input  logic        needUpdate,
  output walkStrobe_t strobe,
  output logic        busy,
  output logic        memReq,
  output logic        memWe,
  output logic        rspValid,
  output walkCause_e  rspCause
);
  walkState_e state, stateNext;
  walkCause_e causeReg, causeNext;
  logic       causeLoad;
  walkState_e finalState;
  walkCause_e finalCause;

  assign finalState = !permOk ? ST_RESP : (needUpdate ? ST_WRBACK : ST_RESP);
  assign finalCause = permOk ? CAUSE_NONE : CAUSE_DENIED;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    memReq    = 1'b0;
    memWe     = 1'b0;
    causeLoad = 1'b0;
    causeNext = CAUSE_NONE;
    unique case (state)
      ST_IDLE: if (reqValid) begin
        strobe.loadReq = 1'b1;
        stateNext      = ST_RD_DIR;
      end
      ST_RD_DIR: begin
        memReq = 1'b1;
        if (memDone) begin
          strobe.loadEntry = 1'b1;
          stateNext        = ST_CHK_DIR;
        end
      end
      ST_CHK_DIR: begin
        causeLoad = 1'b1;
        if (!entPresent) begin
          causeNext = CAUSE_ABSENT;
          stateNext = ST_RESP;
        end else if (entLarge) begin
          causeNext = finalCause;
          stateNext = finalState;
        end else begin
          strobe.descend = 1'b1;
          stateNext      = ST_RD_PTE;
        end
      end
      ST_RD_PTE: begin
        memReq = 1'b1;
        if (memDone) begin
          strobe.loadEntry = 1'b1;
          stateNext        = ST_CHK_PTE;
        end
      end
      ST_CHK_PTE: begin
        causeLoad = 1'b1;
        if (!entPresent) begin
          causeNext = CAUSE_ABSENT;
          stateNext = ST_RESP;
        end else begin
          causeNext = finalCause;
          stateNext = finalState;
        end
      end
      ST_WRBACK: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memDone) stateNext = ST_RESP;
      end
      ST_RESP: if (rspAck) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      causeReg <= CAUSE_NONE;
    end else begin
      state <= stateNext;
      if (causeLoad) causeReg <= causeNext;
    end
  end

  assign busy     = (state != ST_IDLE) && (state != ST_RESP);
  assign rspValid = (state == ST_RESP);
  assign rspCause = causeReg;

  // R9: response is held with its cause until acknowledged
  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspAck) |=> (rspValid && $stable(rspCause)));
  // R10: an outstanding memory request is not withdrawn before done
  assert_mem_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memDone) |=> (memReq && $stable(memWe)));
  // R9: a new request is never taken while a response waits
  assert_no_accept_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspAck) |=> !busy);
endmodule

// File: rtl/page_walker.sv
module page_walker
  import pgw_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int IDX_W = 10,
  parameter int OFF_W = 12
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  rootWrEn,
  input  logic [VA_W-OFF_W-1:0] rootWrData,
  input  logic                  reqValid,
  input  logic [VA_W-1:0]       reqVaddr,
  input  logic                  reqWrite,
  input  logic                  reqUser,
  output logic                  busy,
  output logic                  memReq,
  output logic                  memWe,
  output logic [VA_W-1:0]       memAddr,
  output logic [VA_W-1:0]       memWdata,
  input  logic                  memDone,
  input  logic [VA_W-1:0]       memRdata,
  output logic                  rspValid,
  output logic [1:0]            rspCause,
  output logic [VA_W-1:0]       rspPaddr,
  output logic                  rspWriteThrough,
  output logic                  rspCacheDisable,
  input  logic                  rspAck
);
  walkStrobe_t     strobe;
  walkCause_e      cause;
  logic            entPresent, entLarge, permOk, needUpdate;
  logic            entWriteThrough, entCacheDisable;
  logic [VA_W-1:0] pagePaddr;
  logic            okRsp;

  pgw_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .memDone(memDone), .rspAck(rspAck),
    .entPresent(entPresent), .entLarge(entLarge), .permOk(permOk), .needUpdate(needUpdate),
    .strobe(strobe), .busy(busy), .memReq(memReq), .memWe(memWe),
    .rspValid(rspValid), .rspCause(cause)
  );

  pgw_datapath #(.VA_W(VA_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rootWrEn(rootWrEn), .rootWrData(rootWrData),
    .reqVaddr(reqVaddr), .reqWrite(reqWrite), .reqUser(reqUser), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata), .entPresent(entPresent), .entLarge(entLarge),
    .permOk(permOk), .needUpdate(needUpdate), .pagePaddr(pagePaddr),
    .entWriteThrough(entWriteThrough), .entCacheDisable(entCacheDisable)
  );

  assign okRsp           = (cause == CAUSE_NONE);
  assign rspCause        = cause;
  assign rspPaddr        = okRsp ? pagePaddr : '0;
  assign rspWriteThrough = okRsp && entWriteThrough;
  assign rspCacheDisable = okRsp && entCacheDisable;

  // R10: address and write data stay put while the memory is working
  assert_addr_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memDone) |=> ($stable(memAddr) && $stable(memWdata)));
  // R9: the translated address does not move while the response waits
  assert_paddr_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspAck) |=> $stable(rspPaddr));
endmodule

// File: tb/page_walker_bench.sv
module page_walker_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rootWrEn = 1'b0;
  logic [19:0] rootWrData = '0;
  logic        reqValid = 1'b0;
  logic [31:0] reqVaddr = '0;
  logic        reqWrite = 1'b0;
  logic        reqUser = 1'b0;
  logic        busy, memReq, memWe, rspValid, rspWriteThrough, rspCacheDisable;
  logic [31:0] memAddr, memWdata, rspPaddr;
  logic [1:0]  rspCause;
  logic        memDone = 1'b0;
  logic [31:0] memRdata = '0;
  logic        rspAck = 1'b0;

  always #5 clk = ~clk;

  page_walker u_page_walker (
    .clk(clk), .rstN(rstN), .rootWrEn(rootWrEn), .rootWrData(rootWrData),
    .reqValid(reqValid), .reqVaddr(reqVaddr), .reqWrite(reqWrite), .reqUser(reqUser),
    .busy(busy), .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memDone(memDone), .memRdata(memRdata), .rspValid(rspValid), .rspCause(rspCause),
    .rspPaddr(rspPaddr), .rspWriteThrough(rspWriteThrough), .rspCacheDisable(rspCacheDisable),
    .rspAck(rspAck)
  );

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  int latency = 0;
  int waitCnt = 0;
  logic [31:0] rootFrame = '0;
  logic [31:0] mem [logic [31:0]];
  logic [31:0] trAddr [$];
  logic [31:0] trData [$];
  logic        trWe   [$];

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic finish();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // memory model, per-clock checks and watchdog
  initial begin
    forever begin
      @(negedge clk);
      cycles++;
      if (rstN) chk({31'b0, busy && rspValid}, 32'h0, "R9 busy and rspValid together");
      if (memDone) memDone = 1'b0;
      else if (memReq) begin
        if (waitCnt < latency) waitCnt++;
        else begin
          waitCnt = 0;
          trAddr.push_back(memAddr);
          trWe.push_back(memWe);
          trData.push_back(memWe ? memWdata : 32'h0);
          if (memWe) mem[memAddr] = memWdata;
          else memRdata = rd(memAddr);
          memDone = 1'b1;
        end
      end
      if (cycles > 150000) begin
        errors++;
        checks++;
        $display("FAIL watchdog R9 actual=%0d expected<150000 cycles", cycles);
        finish();
      end
    end
  end

  task automatic setRoot(input logic [19:0] f);
    @(negedge clk);
    rootWrEn = 1'b1; rootWrData = f;
    @(negedge clk);
    rootWrEn = 1'b0;
    rootFrame = {f, 12'h0};
  endtask

  task automatic waitRsp(input string tag);
    int n = 0;
    while (!rspValid && n < 400) begin @(negedge clk); n++; end
    if (!rspValid) chk(32'h0, 32'h1, {tag, " R9 response timeout"});
  endtask

  task automatic walk(input logic [31:0] va, input logic wr, input logic usr, input string tag);
    logic [31:0] eA [$];
    logic [31:0] eD [$];
    logic        eW [$];
    logic [31:0] d, p, fin, finA, pa, dA, pA;
    logic [1:0]  cause;
    cause = 2'd0; pa = 32'h0; fin = 32'h0; finA = 32'h0;
    dA = {rootFrame[31:12], va[31:22], 2'b00};
    d = rd(dA);
    eA.push_back(dA); eW.push_back(1'b0); eD.push_back(32'h0);
    if (!d[0]) cause = 2'd1;
    else if (d[7]) begin fin = d; finA = dA; pa = {d[31:22], va[21:0]}; end
    else begin
      pA = {d[31:12], va[21:12], 2'b00};
      p = rd(pA);
      eA.push_back(pA); eW.push_back(1'b0); eD.push_back(32'h0);
      if (!p[0]) cause = 2'd1;
      else begin fin = p; finA = pA; pa = {p[31:12], va[11:0]}; end
    end
    if (cause == 2'd0 && ((wr && !fin[1]) || (usr && !fin[2]))) cause = 2'd2;
    if (cause == 2'd0 && (!fin[5] || (wr && !fin[6]))) begin
      eA.push_back(finA); eW.push_back(1'b1);
      eD.push_back(fin | 32'h20 | (wr ? 32'h40 : 32'h0));
    end
    trAddr.delete(); trWe.delete(); trData.delete();
    @(negedge clk);
    reqValid = 1'b1; reqVaddr = va; reqWrite = wr; reqUser = usr;
    @(negedge clk);
    reqValid = 1'b0;
    waitRsp(tag);
    chk({30'b0, rspCause}, {30'b0, cause}, {tag, " cause"});
    chk(rspPaddr, (cause == 2'd0) ? pa : 32'h0, {tag, " paddr"});
    chk({31'b0, rspWriteThrough}, {31'b0, cause == 2'd0 && fin[3]}, {tag, " R8 write-through"});
    chk({31'b0, rspCacheDisable}, {31'b0, cause == 2'd0 && fin[4]}, {tag, " R8 cache-disable"});
    chk(trAddr.size(), eA.size(), {tag, " access count"});
    for (int i = 0; i < eA.size() && i < trAddr.size(); i++) begin
      chk(trAddr[i], eA[i], {tag, " R2 access address"});
      chk({31'b0, trWe[i]}, {31'b0, eW[i]}, {tag, " R7 access kind"});
      chk(trData[i], eD[i], {tag, " R7 write data"});
    end
    @(negedge clk);
    rspAck = 1'b1;
    @(negedge clk);
    rspAck = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({29'b0, busy, rspValid, memReq}, 32'h0, "R1 outputs in reset");
    rstN = 1'b1;
    @(negedge clk);
    chk({29'b0, busy, rspValid, memReq}, 32'h0, "R1 outputs after reset");
    setRoot(20'h00100);
    // directory entries at root 0x00100000
    mem[32'h0010_0004] = 32'h0020_0007;            // idx1 -> table 0x00200000, P W U
    mem[32'h0010_0008] = 32'h0030_0003;            // idx2 -> table 0x00300000, P W (kernel)
    mem[32'h0010_000C] = 32'h0000_0006;            // idx3 not present
    mem[32'h0010_0010] = 32'h3040_00A7;            // idx4 large page, P W U A
    mem[32'h0010_0014] = 32'h5080_0085;            // idx5 large page, P U, read-only, not accessed
    // second-level entries
    mem[32'h0020_0004] = 32'h1234_502F;            // P W U WT A
    mem[32'h0020_0008] = 32'h2222_2037;            // P W U CD A (not dirty)
    mem[32'h0020_000C] = 32'h3333_3015;            // P U CD, not accessed, read-only
    mem[32'h0020_0010] = 32'h4444_4006;            // not present
    mem[32'h0030_0004] = 32'h5555_5063;            // P W A D, kernel only

    walk(32'h0040_1ABC, 1'b0, 1'b1, "R3 4K read");
    walk(32'h0040_2123, 1'b1, 1'b1, "R7 write marks dirty");
    walk(32'h0040_2124, 1'b1, 1'b1, "R7 no second write-back");
    walk(32'h0040_3FFF, 1'b0, 1'b1, "R7 accessed mark on read");
    walk(32'h0040_3000, 1'b1, 1'b1, "R6 write to read-only");
    walk(32'h00C0_0000, 1'b0, 1'b0, "R4 directory absent");
    walk(32'h0040_4010, 1'b0, 1'b0, "R4 page absent");
    walk(32'h0080_1777, 1'b0, 1'b1, "R6 user to kernel page");
    walk(32'h0080_1777, 1'b1, 1'b0, "R3 kernel write");
    latency = 2;
    walk(32'h0103_4567, 1'b1, 1'b1, "R5 large page write");
    walk(32'h0142_BCDE, 1'b0, 1'b1, "R5 large page accessed mark");
    walk(32'h0142_BCDE, 1'b1, 1'b1, "R6 large read-only write");
    walk(32'h0040_1000, 1'b0, 1'b0, "R10 slow memory");
    latency = 0;
    // R2: a new top-table frame moves the first read
    setRoot(20'h00200);
    walk(32'h0000_1FFC, 1'b0, 1'b0, "R2 new root");
    setRoot(20'h00100);

    // R9: extra request during a walk, held response
    trAddr.delete(); trWe.delete(); trData.delete();
    @(negedge clk);
    reqValid = 1'b1; reqVaddr = 32'h0040_1004; reqWrite = 1'b0; reqUser = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    chk({31'b0, busy}, 32'h1, "R9 busy after accept");
    reqValid = 1'b1; reqVaddr = 32'h0080_1000; reqWrite = 1'b0; reqUser = 1'b0;
    @(negedge clk);
    reqValid = 1'b0;
    waitRsp("R9 overlap");
    reqValid = 1'b1; reqVaddr = 32'h00C0_0000;
    repeat (3) begin
      @(negedge clk);
      chk({31'b0, rspValid}, 32'h1, "R9 response held");
      chk(rspPaddr, 32'h1234_5004, "R9 paddr held");
    end
    reqValid = 1'b0;
    rspAck = 1'b1;
    @(negedge clk);
    rspAck = 1'b0;
    repeat (4) @(negedge clk);
    chk({30'b0, busy, rspValid}, 32'h0, "R9 ignored request left idle");
    chk(trAddr.size(), 32'd2, "R9 only one walk accessed memory");
    finish();
  end
endmodule